// File: doc/BRIEF.md
# Address Window Decoder

This block sits on the outgoing address path of a memory-moving engine and decides which of up to eight programmed address windows an access falls into. Each window has an enable bit and a two-bit permission field, both held in one shared control word. It also has a base register that carries a target attribute byte, and a size register that gives the window length as a count of 64 KB granules minus one. For every access request the decoder reports, one clock later, whether a window was selected, which one, its attribute byte and its permission field. An access that matches no enabled window, or that its window forbids, gives a one-cycle error pulse and no selection.

Software programs all windows through a simple indexed register write port. One extra register is a global address override. While it holds a nonzero value, its upper half replaces the upper address bits of each request for matching. Writing zero turns the override off.

Top module: `awd_decoder`

## Requirements
- R1: After reset all windows are disabled, the override register is zero, and all outputs are low. The first request after reset therefore gives an error pulse.
- R2: Bit i of the control word (register index 0) enables window i. A disabled window never selects, whatever its base and size.
- R3: Window i matches when `addr[31:16] & ~mask` equals `base[31:16] & ~mask`, where `mask` is bits [31:16] of its size register and holds (window length / 64 KB) - 1. A 64 KB window uses mask 0.
- R4: On a selection, `sel_attr` equals bits [15:8] of the selected window's base register, and `sel_perm` equals its permission field.
- R5: When several enabled windows match, the one with the lowest index is selected.
- R6: The permission field of window i is control bits [17+2i:16+2i]. Bit 1 allows writes and bit 0 allows reads, so 2'b11 means full access. An access that the field forbids gives an error and no selection.
- R7: A miss or a forbidden access raises `err` for exactly one cycle. `sel_valid` stays low, and `sel_idx`, `sel_attr` and `sel_perm` are zero.
- R8: The override register is at index 1. While it is nonzero, its bits [31:16] replace `req_addr[31:16]` for matching. Writing zero turns the override off.
- R9: The outputs are registered. They answer the request presented on the previous clock edge. A cycle with no request gives `sel_valid` and `err` both low.
- R10: Register index 2+2i is the base of window i and index 3+2i is its size. A write to an index above 2*NUM_WIN+1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| sel_valid | output | 1 | A window was selected |
| sel_idx | output | 3 | Selected window index |
| sel_attr | output | 8 | Target attribute of the selected window |
| sel_perm | output | 2 | Permission field of the selected window |
| err | output | 1 | Miss or forbidden-access pulse |

## Verification
Some properties are checked on every cycle. Selection and error are never high together. The priority grant is at most one-hot and never picks a window that did not match, nor one above a lower matching window. A write selection always carries write permission, and a request always yields exactly one of selection or error on the next cycle. Other behaviours can only be shown by the bench's scenarios, because they depend on programmed contents. These are the granule-mask boundaries, the attribute byte returned, the override redirecting a lookup and then releasing it, enable bits masking a programmed window, and writes to unused indices.

// File: rtl/awd_pkg.sv
package awd_pkg;
   localparam int ATTR_W    = 8;
   localparam int ATTR_LSB  = 8;
   localparam int PERM_W    = 2;
   localparam int PERM_BASE = 16;

   typedef logic [PERM_W-1:0] perm_t;
   typedef logic [ATTR_W-1:0] attr_t;

   // permission bit 1 = write allowed, bit 0 = read allowed
   function automatic logic perm_allows(perm_t p, logic is_write);
      return is_write ? p[1] : p[0];
   endfunction
endpackage

// File: rtl/awd_regs.sv
module awd_regs
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int DATA_W    = 32,
   parameter int GRAN_BITS = 16,
   parameter int IDX_W     = 5,
   localparam int HI_W     = DATA_W - GRAN_BITS
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NUM_WIN-1:0]            win_en,
   output perm_t [NUM_WIN-1:0]           win_perm,
   output logic [NUM_WIN-1:0][HI_W-1:0]  win_base,
   output logic [NUM_WIN-1:0][HI_W-1:0]  win_mask,
   output attr_t [NUM_WIN-1:0]           win_attr,
   output logic [DATA_W-1:0]             ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_en   <= '0;
         win_perm <= '0;
         ovr      <= '0;
      end else if (wr_en) begin
         if (wr_idx == IDX_W'(0)) begin
            win_en   <= wr_data[NUM_WIN-1:0];
            win_perm <= wr_data[PERM_BASE +: PERM_W*NUM_WIN];
         end
         if (wr_idx == IDX_W'(1)) ovr <= wr_data;
      end
   end

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_base[i] <= '0;
            win_attr[i] <= '0;
            win_mask[i] <= '0;
         end else if (wr_en) begin
            if (wr_idx == IDX_W'(2 + 2*i)) begin
               win_base[i] <= wr_data[DATA_W-1:GRAN_BITS];
               win_attr[i] <= wr_data[ATTR_LSB +: ATTR_W];
            end
            if (wr_idx == IDX_W'(3 + 2*i)) win_mask[i] <= wr_data[DATA_W-1:GRAN_BITS];
         end
      end
   end

   // R8
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(1) && wr_data == '0) |=> (ovr == '0));
endmodule

// File: rtl/awd_match.sv
module awd_match #(
   parameter int HI_W = 16
) (
   input  logic            en,
   input  logic [HI_W-1:0] addr_hi,
   input  logic [HI_W-1:0] base_hi,
   input  logic [HI_W-1:0] mask,
   output logic            hit
);
   always_comb hit = en && ((addr_hi & ~mask) == (base_hi & ~mask));
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      hits,
   output logic              any,
   output logic [IDX_W-1:0]  idx
);
   logic [N-1:0] grant;

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (hits[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            idx = IDX_W'(i);
         end
      end
      any = |hits;
   end

   // R5
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~hits) == '0));
   // R5
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((hits & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 16,
   localparam int HI_W     = ADDR_W - GRAN_BITS,
   localparam int IDX_W    = $clog2(2 + 2*NUM_WIN),
   localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              sel_valid,
   output logic [WIN_W-1:0]  sel_idx,
   output attr_t             sel_attr,
   output perm_t             sel_perm,
   output logic              err
);
   if (NUM_WIN < 1 || NUM_WIN > PERM_BASE) begin : g_bad_win
      $error("NUM_WIN out of range");
   end
   if (PERM_BASE + PERM_W*NUM_WIN > ADDR_W) begin : g_bad_ctrl
      $error("control word too narrow for permissions");
   end
   if (GRAN_BITS < ATTR_LSB + ATTR_W || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("GRAN_BITS must leave room for the attribute byte");
   end

   logic [NUM_WIN-1:0]           win_en, hits;
   perm_t [NUM_WIN-1:0]          win_perm;
   logic [NUM_WIN-1:0][HI_W-1:0] win_base, win_mask;
   attr_t [NUM_WIN-1:0]          win_attr;
   logic [ADDR_W-1:0]            ovr;
   logic [HI_W-1:0]              look_hi;
   logic                         any;
   logic [WIN_W-1:0]             widx;
   logic                         unused_lo;

   assign unused_lo = ^req_addr[GRAN_BITS-1:0];

   awd_regs #(.NUM_WIN(NUM_WIN), .DATA_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .win_en(win_en), .win_perm(win_perm), .win_base(win_base), .win_mask(win_mask),
      .win_attr(win_attr), .ovr(ovr));

   assign look_hi = (ovr != '0) ? ovr[ADDR_W-1:GRAN_BITS] : req_addr[ADDR_W-1:GRAN_BITS];

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
      awd_match #(.HI_W(HI_W)) u_match (
         .en(win_en[i]), .addr_hi(look_hi), .base_hi(win_base[i]),
         .mask(win_mask[i]), .hit(hits[i]));
   end

   awd_prio #(.N(NUM_WIN), .IDX_W(WIN_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .hits(hits), .any(any), .idx(widx));

   logic ok;
   always_comb ok = any && perm_allows(win_perm[widx], req_write);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_idx   <= '0;
         sel_attr  <= '0;
         sel_perm  <= '0;
         err       <= 1'b0;
      end else begin
         sel_valid <= req_valid && ok;
         err       <= req_valid && !ok;
         sel_idx   <= (req_valid && ok) ? widx : '0;
         sel_attr  <= (req_valid && ok) ? win_attr[widx] : '0;
         sel_perm  <= (req_valid && ok) ? win_perm[widx] : '0;
      end
   end

   // R7
   sel_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_valid && err));
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!sel_valid && !err));
   // R9
   req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (sel_valid || err));
   // R6
   write_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && $past(req_write)) |-> sel_perm[1]);
endmodule

// File: tb/tb_awd_decoder.sv
module tb_awd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        sel_valid, err;
   logic [2:0]  sel_idx;
   logic [7:0]  sel_attr;
   logic [1:0]  sel_perm;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   awd_decoder dut (.*);

   typedef struct packed {
      logic [31:0] a; logic w; logic v; logic [2:0] i; logic [7:0] at; logic [1:0] p; logic e;
   } vec_t;

   // R3 R4 R5 R6 R7 vectors: {addr, write, valid, idx, attr, perm, err}
   localparam vec_t VEC [12] = '{
      '{32'h0123_4567, 1'b0, 1'b1, 3'd0, 8'h0E, 2'b11, 1'b0},
      '{32'h0FFF_FFFF, 1'b1, 1'b1, 3'd0, 8'h0E, 2'b11, 1'b0},
      '{32'h1000_0000, 1'b0, 1'b1, 3'd1, 8'h0D, 2'b01, 1'b0},
      '{32'h1800_0000, 1'b1, 1'b0, 3'd0, 8'h00, 2'b00, 1'b1},
      '{32'h2000_ABCD, 1'b0, 1'b1, 3'd2, 8'h0B, 2'b11, 1'b0},
      '{32'h2001_0000, 1'b0, 1'b1, 3'd3, 8'h07, 2'b11, 1'b0},
      '{32'h20FF_FFFF, 1'b1, 1'b1, 3'd3, 8'h07, 2'b11, 1'b0},
      '{32'h2100_0000, 1'b0, 1'b0, 3'd0, 8'h00, 2'b00, 1'b1},
      '{32'h400F_FFFF, 1'b1, 1'b1, 3'd4, 8'h1F, 2'b10, 1'b0},
      '{32'h4000_0000, 1'b0, 1'b0, 3'd0, 8'h00, 2'b00, 1'b1},
      '{32'h8000_0000, 1'b0, 1'b0, 3'd0, 8'h00, 2'b00, 1'b1},
      '{32'h4010_0000, 1'b1, 1'b0, 3'd0, 8'h00, 2'b00, 1'b1}
   };

   function automatic logic [14:0] pack(logic v, logic [2:0] i, logic [7:0] at, logic [1:0] p, logic e);
      return {v, i, at, p, e};
   endfunction

   task automatic check(string tag, logic [14:0] exp);
      logic [14:0] got = pack(sel_valid, sel_idx, sel_attr, sel_perm, err);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [4:0] idx, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic look(logic [31:0] a, logic w, string tag, logic [14:0] exp);
      @(negedge clk); req_valid = 1'b1; req_addr = a; req_write = w;
      @(negedge clk); check(tag, exp); req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 15'h0);
      rst_n = 1'b1;
      look(32'h0000_0000, 1'b0, "R1 miss after reset", pack(0, 0, 0, 0, 1));
      @(negedge clk); check("R7 error lasts one cycle", 15'h0);

      wr(5'd2,  32'h0000_0E00); wr(5'd3,  32'h0FFF_0000);
      wr(5'd4,  32'h1000_0D00); wr(5'd5,  32'h0FFF_0000);
      wr(5'd6,  32'h2000_0B00); wr(5'd7,  32'h0000_0000);
      wr(5'd8,  32'h2000_0700); wr(5'd9,  32'h00FF_0000);
      wr(5'd10, 32'h4000_1F00); wr(5'd11, 32'h000F_0000);
      wr(5'd12, 32'h8000_5500); wr(5'd13, 32'h0000_0000);
      wr(5'd0,  32'h0EF7_001F);

      for (int k = 0; k < 12; k++)
         look(VEC[k].a, VEC[k].w, $sformatf("R3/R4/R5/R6 vector %0d", k),
              pack(VEC[k].v, VEC[k].i, VEC[k].at, VEC[k].p, VEC[k].e));

      @(negedge clk); check("R9 no request no output", 15'h0);

      // R8 override redirects, then zero releases
      wr(5'd1, 32'h2001_0000);
      look(32'h0000_1234, 1'b0, "R8 override active", pack(1, 3'd3, 8'h07, 2'b11, 0));
      wr(5'd1, 32'h0000_0000);
      look(32'h0000_1234, 1'b0, "R8 override released", pack(1, 3'd0, 8'h0E, 2'b11, 0));

      // R10 out-of-range index has no effect
      wr(5'd31, 32'hFFFF_FFFF);
      look(32'h0123_4567, 1'b0, "R10 ignored index", pack(1, 3'd0, 8'h0E, 2'b11, 0));

      // R2 enable bits
      wr(5'd0, 32'h0EF7_003E);
      look(32'h0123_4567, 1'b0, "R2 disabled window 0", pack(0, 0, 0, 0, 1));
      wr(5'd0, 32'h0EF7_003F);
      look(32'h8000_0000, 1'b0, "R2 enabled window 5", pack(1, 3'd5, 8'h55, 2'b11, 0));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule